// File: doc/BRIEF.md
# Interrupt Source Gate

This block keeps the configuration of a small set of interrupt sources and decides, every cycle, which of them is offered to which destination processor. Each source has two 32-bit registers. The control word holds the mask, the sense mode, the priority and the vector. The routing word holds one enable bit per destination. Software reaches both registers through a word-wide port. Each source has an input line that the block samples and treats as either level- or edge-triggered.

A source that is unmasked, has a non-zero priority, has at least one routing bit set, is not already in service and has a pending event is a candidate. It is offered to every destination whose routing bit is set and whose 4-bit task priority is strictly lower than the source priority. Each destination takes its best candidate and receives a registered one-cycle request. The request carries the source index, the priority and the vector. A source that is accepted by any destination gets its read-only activity bit set. That bit blocks the source from being offered again until the bit is cleared. A level source clears the bit when its input falls. An edge source clears it when the delivery logic returns an acknowledge strobe that names the source.

Top module: `irq_src_gate`

## Requirements
- R1: After reset every control word reads 0xA0000000 (masked), every routing word reads 0, and no request is raised.
- R2: Control word layout: bit 31 is the mask, bit 30 is the activity bit, bit 22 selects level sense when 1 and edge sense when 0, bits 20:16 hold the priority and bits VEC_W-1:0 hold the vector. Other bits are stored and read back. A write never changes bit 30; the value read back always shows the current activity state.
- R3: A routing-word write keeps bits 31:30 and bits NUM_DST-1:0 and forces every other bit to 0. Routing bit d enables destination d.
- R4: A register access whose source index is NUM_SRC or above reads back 0, and a write to such an index has no effect.
- R5: A source raises no request while any of these holds: it is masked, its priority is 0, its activity bit is set, or its routing word has no destination bit. Once the blocking condition is removed and the event is still pending, the source is delivered.
- R6: In level mode the pending state follows the sampled input. When the input is low, the activity bit clears. The acknowledge strobe has no effect on a level source.
- R7: In edge mode a rising edge of the sampled input latches a pending event, and the event stays latched until the source is delivered. This includes edges that arrive while the activity bit is set. The activity bit of an edge source is cleared only by an acknowledge whose index matches the source.
- R8: A request goes to every destination whose routing bit is set, but only where the source priority is strictly greater than that destination's task priority (task_prio[4d+3:4d]).
- R9: Each destination receives at most one request per cycle: the candidate with the highest priority, with ties going to the lowest index. A request lasts one cycle, carries index, priority and vector, and sets the source's activity bit. An input change shows up as a request after two clock edges; a register write that unblocks a source shows up after two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the routing word |
| reg_idx | input | IDX_W | Source index for register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the address presented in the previous cycle |
| irq_in | input | NUM_SRC | Interrupt input lines, one per source |
| task_prio | input | NUM_DST*4 | Current task priority of each destination |
| ack_valid | input | 1 | Acknowledge strobe that clears activity of an edge source |
| ack_idx | input | IDX_W | Source index of the acknowledge |
| req_valid | output | NUM_DST | One-cycle request per destination |
| req_idx | output | NUM_DST*IDX_W | Source index of each request |
| req_prio | output | NUM_DST*5 | Priority of each request |
| req_vec | output | NUM_DST*VEC_W | Vector of each request |

## Verification
The assertions assume that reset is high from the first clock edge and lasts at least one edge. They also assume that irq_in, task_prio and the register port are synchronous to clk, so the values one cycle back are the ones the selection used. The bench drives every input only on the falling edge and holds reset from time zero. It changes task priorities only between requests, and it checks the request ordering through an in-order expectation queue for both destinations.

// File: rtl/irqg_pkg.sv
`timescale 1ns/1ps
package irqg_pkg;
  localparam int REG_W     = 32;
  localparam int MASK_BIT  = 31;
  localparam int ACT_BIT   = 30;
  localparam int SENSE_BIT = 22;
  localparam int PRIO_LSB  = 16;
  localparam int PRIO_W    = 5;
  localparam int TASK_W    = 4;
  localparam logic [REG_W-1:0] CTRL_RESET = 32'hA000_0000;
  typedef enum logic {SEL_CTRL = 1'b0, SEL_ROUTE = 1'b1} reg_sel_e;
endpackage

// File: rtl/irqg_regs.sv
`timescale 1ns/1ps
module irqg_regs
  import irqg_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int NUM_DST = 2,
  parameter int VEC_W   = 8,
  parameter int IDX_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic                       sel,
  input  logic [IDX_W-1:0]           idx,
  input  logic [REG_W-1:0]           wdata,
  input  logic [NUM_SRC-1:0]         act,
  output logic [REG_W-1:0]           rdata,
  output logic [NUM_SRC-1:0]         src_mask,
  output logic [NUM_SRC-1:0]         src_level,
  output logic [NUM_SRC*PRIO_W-1:0]  src_prio,
  output logic [NUM_SRC*VEC_W-1:0]   src_vec,
  output logic [NUM_SRC*NUM_DST-1:0] src_dst
);
  localparam int ZERO_W = REG_W - 2 - NUM_DST;
  localparam logic [REG_W-1:0] ROUTE_KEEP = {2'b11, {ZERO_W{1'b0}}, {NUM_DST{1'b1}}};

  logic [REG_W-1:0] ctrl_q  [NUM_SRC];
  logic [REG_W-1:0] route_q [NUM_SRC];
  logic             idx_ok;
  logic [REG_W-1:0] ctrl_view;

  assign idx_ok = (32'(idx) < 32'(NUM_SRC));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        ctrl_q[s]  <= CTRL_RESET;
        route_q[s] <= '0;
      end
    end else if (we && idx_ok) begin
      if (sel == SEL_ROUTE) route_q[idx] <= wdata & ROUTE_KEEP;
      else                  ctrl_q[idx]  <= {wdata[REG_W-1:ACT_BIT+1], 1'b0, wdata[ACT_BIT-1:0]};
    end
  end

  always_comb begin
    ctrl_view          = ctrl_q[idx];
    ctrl_view[ACT_BIT] = act[idx];
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (!idx_ok) rdata <= '0;
    else              rdata <= (sel == SEL_ROUTE) ? route_q[idx] : ctrl_view;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_fld
    assign src_mask[s]                    = ctrl_q[s][MASK_BIT];
    assign src_level[s]                   = ctrl_q[s][SENSE_BIT];
    assign src_prio[s*PRIO_W +: PRIO_W]   = ctrl_q[s][PRIO_LSB +: PRIO_W];
    assign src_vec[s*VEC_W +: VEC_W]      = ctrl_q[s][VEC_W-1:0];
    assign src_dst[s*NUM_DST +: NUM_DST]  = route_q[s][NUM_DST-1:0];
  end
endmodule

// File: rtl/irqg_track.sv
`timescale 1ns/1ps
module irqg_track #(
  parameter int NUM_SRC = 6,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] level,
  input  logic [NUM_SRC-1:0] grant,
  input  logic               ack_valid,
  input  logic [IDX_W-1:0]   ack_idx,
  output logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] act
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic in_q, in_prev, edge_q, act_q;
    logic rise, ack_hit;

    assign rise    = in_q & ~in_prev;
    assign ack_hit = ack_valid && (ack_idx == IDX_W'(s));
    assign pend[s] = level[s] ? in_q : (edge_q | rise);
    assign act[s]  = act_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        in_q    <= 1'b0;
        in_prev <= 1'b0;
        edge_q  <= 1'b0;
        act_q   <= 1'b0;
      end else begin
        in_q    <= irq_in[s];
        in_prev <= in_q;
        edge_q  <= (edge_q | rise) & ~grant[s] & ~level[s];
        if (grant[s])                          act_q <= 1'b1;
        else if (level[s] ? !in_q : ack_hit)   act_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irqg_pick.sv
`timescale 1ns/1ps
module irqg_pick
  import irqg_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0]        cand,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  output logic                      hit,
  output logic [IDX_W-1:0]          win,
  output logic [PRIO_W-1:0]         best
);
  always_comb begin
    hit  = 1'b0;
    win  = '0;
    best = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (cand[s] && (!hit || prio[s*PRIO_W +: PRIO_W] > best)) begin
        hit  = 1'b1;
        win  = IDX_W'(s);
        best = prio[s*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_src_gate.sv
`timescale 1ns/1ps
module irq_src_gate
  import irqg_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int NUM_DST = 2,
  parameter int VEC_W   = 8,
  parameter int IDX_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_we,
  input  logic                       reg_sel,
  input  logic [IDX_W-1:0]           reg_idx,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  logic [NUM_SRC-1:0]         irq_in,
  input  logic [NUM_DST*4-1:0]       task_prio,
  input  logic                       ack_valid,
  input  logic [IDX_W-1:0]           ack_idx,
  output logic [NUM_DST-1:0]         req_valid,
  output logic [NUM_DST*IDX_W-1:0]   req_idx,
  output logic [NUM_DST*5-1:0]       req_prio,
  output logic [NUM_DST*VEC_W-1:0]   req_vec
);
  localparam int MAP_W = NUM_DST * NUM_SRC;

  logic [NUM_SRC-1:0]         src_mask, src_level, act, pend, grant, base_ok;
  logic [NUM_SRC*PRIO_W-1:0]  src_prio;
  logic [NUM_SRC*VEC_W-1:0]   src_vec;
  logic [NUM_SRC*NUM_DST-1:0] src_dst;
  logic [MAP_W-1:0]           sel_map;

  irqg_regs #(.NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .idx(reg_idx), .wdata(reg_wdata),
    .act(act), .rdata(reg_rdata), .src_mask(src_mask), .src_level(src_level),
    .src_prio(src_prio), .src_vec(src_vec), .src_dst(src_dst)
  );

  irqg_track #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_track (
    .clk(clk), .rst(rst), .irq_in(irq_in), .level(src_level), .grant(grant),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .pend(pend), .act(act)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_base
    assign base_ok[s] = !src_mask[s] && (src_prio[s*PRIO_W +: PRIO_W] != '0) && !act[s]
                        && (|src_dst[s*NUM_DST +: NUM_DST]) && pend[s];
  end

  for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
    logic [NUM_SRC-1:0] cand;
    logic               hit;
    logic [IDX_W-1:0]   win;
    logic [PRIO_W-1:0]  best;
    logic               vld_q;
    logic [IDX_W-1:0]   idx_q;
    logic [PRIO_W-1:0]  prio_q;
    logic [VEC_W-1:0]   vec_q;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cand
      assign cand[s] = base_ok[s] && src_dst[s*NUM_DST + d]
                       && (src_prio[s*PRIO_W +: PRIO_W] > PRIO_W'(task_prio[d*TASK_W +: TASK_W]));
      assign sel_map[d*NUM_SRC + s] = hit && (win == IDX_W'(s));
    end

    irqg_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
      .cand(cand), .prio(src_prio), .hit(hit), .win(win), .best(best)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q  <= 1'b0;
        idx_q  <= '0;
        prio_q <= '0;
        vec_q  <= '0;
      end else begin
        vld_q  <= hit;
        idx_q  <= win;
        prio_q <= best;
        vec_q  <= src_vec[win*VEC_W +: VEC_W];
      end
    end

    assign req_valid[d]                 = vld_q;
    assign req_idx[d*IDX_W +: IDX_W]    = idx_q;
    assign req_prio[d*PRIO_W +: PRIO_W] = prio_q;
    assign req_vec[d*VEC_W +: VEC_W]    = vec_q;
  end

  always_comb begin
    grant = '0;
    for (int d = 0; d < NUM_DST; d++)
      for (int s = 0; s < NUM_SRC; s++)
        grant[s] = grant[s] | sel_map[d*NUM_SRC + s];
  end
endmodule

// File: rtl/irqg_chk.sv
`timescale 1ns/1ps
module irqg_chk
  import irqg_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int NUM_DST = 2,
  parameter int IDX_W   = 3
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_DST-1:0]         req_valid,
  input logic [NUM_DST*IDX_W-1:0]   req_idx,
  input logic [NUM_DST*5-1:0]       req_prio,
  input logic [NUM_DST*4-1:0]       task_prio,
  input logic [NUM_SRC-1:0]         src_mask,
  input logic [NUM_SRC*NUM_DST-1:0] src_dst
);
  logic [NUM_SRC-1:0]         mask_q;
  logic [NUM_SRC*NUM_DST-1:0] dst_q;

  always_ff @(posedge clk) begin
    mask_q <= src_mask;
    dst_q  <= src_dst;
  end

  for (genvar d = 0; d < NUM_DST; d++) begin : g_a
    logic [IDX_W-1:0]  ri;
    logic [PRIO_W-1:0] rp;
    assign ri = req_idx[d*IDX_W +: IDX_W];
    assign rp = req_prio[d*PRIO_W +: PRIO_W];

    a_r8_above_task: assert property (@(posedge clk) disable iff (rst)
      req_valid[d] |-> rp > PRIO_W'($past(task_prio[d*TASK_W +: TASK_W])));
    a_r5_prio_nonzero: assert property (@(posedge clk) disable iff (rst)
      req_valid[d] |-> rp != '0);
    a_r9_idx_range: assert property (@(posedge clk) disable iff (rst)
      req_valid[d] |-> 32'(ri) < 32'(NUM_SRC));
    a_r5_unmasked: assert property (@(posedge clk) disable iff (rst)
      req_valid[d] |-> !mask_q[ri]);
    a_r8_route_bit: assert property (@(posedge clk) disable iff (rst)
      req_valid[d] |-> dst_q[32'(ri)*NUM_DST + d]);
    a_r9_no_repeat: assert property (@(posedge clk) disable iff (rst)
      req_valid[d] |=> !(req_valid[d] && ri == $past(ri)));
  end
endmodule

bind irq_src_gate irqg_chk #(.NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_idx(req_idx), .req_prio(req_prio),
  .task_prio(task_prio), .src_mask(src_mask), .src_dst(src_dst)
);

// File: tb/irq_src_gate_tb.sv
`timescale 1ns/1ps
module irq_src_gate_tb;
  localparam int NS = 6, ND = 2, VW = 8, IW = 3;

  logic          clk = 1'b0, rst = 1'b1;
  logic          reg_we = 1'b0, reg_sel = 1'b0;
  logic [IW-1:0] reg_idx = '0;
  logic [31:0]   reg_wdata = '0, reg_rdata;
  logic [NS-1:0] irq_in = '0;
  logic [ND*4-1:0] task_prio = '0;
  logic          ack_valid = 1'b0;
  logic [IW-1:0] ack_idx = '0;
  logic [ND-1:0] req_valid;
  logic [ND*IW-1:0] req_idx;
  logic [ND*5-1:0]  req_prio;
  logic [ND*VW-1:0] req_vec;

  irq_src_gate #(.NUM_SRC(NS), .NUM_DST(ND), .VEC_W(VW), .IDX_W(IW)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in), .task_prio(task_prio),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .req_valid(req_valid), .req_idx(req_idx),
    .req_prio(req_prio), .req_vec(req_vec)
  );

  always #2.5 clk = ~clk;

  typedef struct { int dst; int idx; int prio; int vec; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0, fails = 0, stray = 0;
  bit done = 1'b0;

  task automatic note(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expectations in order, destination 0 before 1 in a cycle
  always @(negedge clk) begin
    if (!rst) begin
      for (int d = 0; d < ND; d++) begin
        if (req_valid[d]) begin
          int ai, ap, av;
          exp_t e;
          ai = int'(req_idx[d*IW +: IW]);
          ap = int'(req_prio[d*5 +: 5]);
          av = int'(req_vec[d*VW +: VW]);
          if (sb.size() == 0) begin
            stray++;
            note(1'b0, "R9", "unexpected request", (d << 24) | (ai << 16) | (ap << 8) | av, 0);
          end else begin
            e = sb.pop_front();
            note(e.dst == d && e.idx == ai && e.prio == ap && e.vec == av, e.tag, "request",
                 (d << 24) | (ai << 16) | (ap << 8) | av,
                 (e.dst << 24) | (e.idx << 16) | (e.prio << 8) | e.vec);
          end
        end
      end
    end
  end

  task automatic push(int d, int i, int p, int v, string tag);
    exp_t e;
    e.dst = d; e.idx = i; e.prio = p; e.vec = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic quiet(string tag, int n);
    int s0;
    s0 = stray;
    repeat (n) @(negedge clk);
    note(stray == s0 && sb.size() == 0, tag, "pending/stray requests", sb.size() + stray - s0, 0);
  endtask

  task automatic wr(bit sel, int idx, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_idx = IW'(idx); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic chk_rd(bit sel, int idx, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_sel = sel; reg_idx = IW'(idx);
    @(negedge clk);
    note(reg_rdata == exp, tag, "readback", reg_rdata, exp);
  endtask

  task automatic line(int s, bit v);
    @(negedge clk);
    irq_in[s] = v;
  endtask

  task automatic ack(int s);
    @(negedge clk);
    ack_valid = 1'b1; ack_idx = IW'(s);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_rd(1'b0, 0, 32'hA000_0000, "R1");
    chk_rd(1'b0, 5, 32'hA000_0000, "R1");
    chk_rd(1'b1, 0, 32'h0, "R1");
    quiet("R1", 3);
    // R4 invalid index
    chk_rd(1'b0, 6, 32'h0, "R4");
    wr(1'b0, 7, 32'hFFFF_FFFF);
    chk_rd(1'b0, 7, 32'h0, "R4");
    chk_rd(1'b1, 7, 32'h0, "R4");
    // R3 routing filter
    wr(1'b1, 0, 32'hFFFF_FFFF);
    chk_rd(1'b1, 0, 32'hC000_0003, "R3");
    wr(1'b1, 0, 32'h1);
    // R2 activity bit not writable; src0 level prio5 vec 21
    wr(1'b0, 0, 32'h4045_0021);
    chk_rd(1'b0, 0, 32'h0045_0021, "R2");
    // R6 level delivery
    push(0, 0, 5, 'h21, "R6");
    line(0, 1'b1);
    quiet("R6", 4);
    chk_rd(1'b0, 0, 32'h4045_0021, "R2");
    ack(0);
    chk_rd(1'b0, 0, 32'h4045_0021, "R6");
    wr(1'b0, 0, 32'h0045_0021);
    chk_rd(1'b0, 0, 32'h4045_0021, "R2");
    line(0, 1'b0);
    repeat (3) @(negedge clk);
    chk_rd(1'b0, 0, 32'h0045_0021, "R6");
    push(0, 0, 5, 'h21, "R6");
    line(0, 1'b1);
    quiet("R6", 4);
    // R7 edge source 1: prio7 vec 32 to destination 1
    wr(1'b1, 1, 32'h2);
    wr(1'b0, 1, 32'h0007_0032);
    push(1, 1, 7, 'h32, "R7");
    line(1, 1'b1);
    quiet("R7", 4);
    chk_rd(1'b0, 1, 32'h4007_0032, "R7");
    line(1, 1'b0);
    line(1, 1'b1);
    quiet("R7", 4);
    push(1, 1, 7, 'h32, "R7");
    ack(1);
    quiet("R7", 4);
    ack(1);
    quiet("R7", 4);
    chk_rd(1'b0, 1, 32'h0007_0032, "R7");
    line(1, 1'b0);
    // R5 mask then unmask
    wr(1'b1, 2, 32'h1);
    wr(1'b0, 2, 32'h8043_0010);
    line(2, 1'b1);
    quiet("R5", 4);
    push(0, 2, 3, 'h10, "R5");
    wr(1'b0, 2, 32'h0043_0010);
    quiet("R5", 4);
    // R5 zero priority and empty routing
    wr(1'b1, 3, 32'h1);
    wr(1'b0, 3, 32'h0040_0013);
    line(3, 1'b1);
    quiet("R5", 4);
    wr(1'b1, 3, 32'h0);
    wr(1'b0, 3, 32'h0044_0013);
    quiet("R5", 4);
    // R8 multicast to both destinations
    push(0, 3, 4, 'h13, "R8");
    push(1, 3, 4, 'h13, "R8");
    wr(1'b1, 3, 32'h3);
    quiet("R8", 4);
    // R8 strict comparison with task priority
    wr(1'b1, 4, 32'h1);
    @(negedge clk); task_prio[3:0] = 4'd4;
    wr(1'b0, 4, 32'h0044_0044);
    line(4, 1'b1);
    quiet("R8", 4);
    push(0, 4, 4, 'h44, "R8");
    @(negedge clk); task_prio[3:0] = 4'd3;
    quiet("R8", 4);
    @(negedge clk); task_prio = '0;
    // R9 higher priority first on destination 1
    wr(1'b1, 5, 32'h2);
    wr(1'b0, 5, 32'h0049_0055);
    push(1, 5, 9, 'h55, "R9");
    push(1, 1, 7, 'h32, "R9");
    @(negedge clk); irq_in[1] = 1'b1; irq_in[5] = 1'b1;
    quiet("R9", 5);
    // R9 tie goes to lower index on destination 0
    @(negedge clk); irq_in[0] = 1'b0; irq_in[2] = 1'b0;
    repeat (3) @(negedge clk);
    wr(1'b0, 2, 32'h0045_0010);
    push(0, 0, 5, 'h21, "R9");
    push(0, 2, 5, 'h10, "R9");
    @(negedge clk); irq_in[0] = 1'b1; irq_in[2] = 1'b1;
    quiet("R9", 5);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule